// File: doc/BRIEF.md
# Serial GPIO Target Frame Receiver

This block is the target (backplane) end of a four-wire serial GPIO link. The initiator drives a serial clock, a frame marker and a data line, and launches changes on all three at the rising edge of the serial clock. The block oversamples the three wires with its own system clock through synchronizers. It takes each data bit at the falling edge of the serial clock, which is mid-bit, so it stays away from the launch edge.

A frame opens when the marker is seen high after a low run of at least `MIN_LOW` samples. That first marked bit is frame bit 0. The frame then carries three bits per slot for `STREAM_SLOTS` slots. The block collects them in shadow registers. It copies them to the parallel per-slot outputs (activity, locate, fail) in one step, only when the whole frame has arrived. While a frame is in progress, the block also returns three response bits per slot, one bit per serial clock, on the return line.

A state machine with four states runs the link. `ST_HUNT` counts marker-low samples. `ST_ARMED` waits for the marker to go high. `ST_FRAME` collects bits. `ST_COMMIT` is a single cycle that publishes the frame. The transitions are: hunt-to-armed on the `MIN_LOW`-th consecutive low sample; armed-to-frame on a high marker sample, which also captures bit 0; frame-to-hunt when the marker is high in mid-frame (abort); frame-to-commit on the last bit; commit-to-armed unconditionally. The last transition is safe because every bit after bit 0 has the marker low, so a completed frame always leaves a low run long enough for the next frame to start.

Top module: `sgpio_target_rx`

## Requirements
- R1: After reset, every slot output, `frame_stb` and `ser_dout` are 0.
- R2: A frame starts only on a high marker sample preceded by at least `MIN_LOW` (default 5) consecutive low marker samples. With a shorter run, the marked bit and the rest of that frame are not stored, and no strobe is produced.
- R3: Frame bit 3k+0 is the activity bit of slot k, bit 3k+1 is its locate bit and bit 3k+2 is its fail bit. Bit 0 is the one sampled with the marker high.
- R4: Slot outputs hold their previous values while a frame is being received, and change only when `frame_stb` is high.
- R5: A high marker sample after bit 0 and before the last bit aborts the frame. The outputs keep their old values, and a new low run of `MIN_LOW` samples is needed before the next frame.
- R6: During frame bit p, `ser_dout` carries response bit p. The response bits are ordered slot k: `rsp_b0[k]`, `rsp_b1[k]`, `rsp_b2[k]`. Bit 0 is already driven in the armed state, before the frame starts.
- R7: Frame bits for slots at or above `NUM_SLOTS` are ignored. In those positions, `ser_dout` is 0.
- R8: Slots at or above `STREAM_SLOTS` read 0.
- R9: `frame_stb` is a one-cycle pulse, given once for each completed frame and never for an aborted or rejected one.
- R10: A new frame may start on the serial clock right after the last bit of the previous frame, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the initiator |
| ser_frm | input | 1 | Frame marker from the initiator |
| ser_din | input | 1 | Serial data from the initiator |
| rsp_b0 | input | NUM_SLOTS | First response bit of each slot |
| rsp_b1 | input | NUM_SLOTS | Second response bit of each slot |
| rsp_b2 | input | NUM_SLOTS | Third response bit of each slot |
| ser_dout | output | 1 | Serial response data to the initiator |
| slot_act | output | NUM_SLOTS | Activity bit of each slot |
| slot_loc | output | NUM_SLOTS | Locate bit of each slot |
| slot_fail | output | NUM_SLOTS | Fail bit of each slot |
| frame_stb | output | 1 | One-cycle pulse when the outputs take a new frame |

## Verification
The bench attacks the low-run threshold with a run of exactly four samples and then exactly five. A design that counted one sample too few would publish the rejected all-ones frame; one that counted one too many would drop the valid one. It aborts frames both before and after a shorter second instance has finished its own frame. A design that published partial data or lost the abort would show wrong outputs or an extra strobe. It also sends frames back to back and checks mid-frame that the outputs hold, which catches a design that needs an idle gap or writes slots as the bits arrive. The response line is checked bit by bit, which exposes an off-by-one in the transmit position or a stray non-zero bit for slots the block does not hold.

// File: rtl/sgpio_rx_pkg.sv
package sgpio_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_FRAME  = 2'd2,
        ST_COMMIT = 2'd3
    } fr_state_t;

    typedef enum logic [1:0] {
        FLD_ACT  = 2'd0,
        FLD_LOC  = 2'd1,
        FLD_FAIL = 2'd2
    } fld_t;

endpackage

// File: rtl/sgpio_rx_sync.sv
module sgpio_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_frm,
    input  logic ser_din,
    output logic sample_ev,
    output logic launch_ev,
    output logic frm_s,
    output logic din_s
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] clk_sh;
    logic [LAST:0] frm_sh;
    logic [LAST:0] din_sh;
    logic          clk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sh <= '0;
            frm_sh <= '0;
            din_sh <= '0;
            clk_d  <= 1'b0;
        end else begin
            clk_sh <= {clk_sh[LAST-1:0], ser_clk};
            frm_sh <= {frm_sh[LAST-1:0], ser_frm};
            din_sh <= {din_sh[LAST-1:0], ser_din};
            clk_d  <= clk_sh[LAST];
        end
    end

    // falling serial edge: data is mid-bit; rising edge: initiator launches
    assign sample_ev = clk_d & ~clk_sh[LAST];
    assign launch_ev = ~clk_d & clk_sh[LAST];
    assign frm_s     = frm_sh[LAST];
    assign din_s     = din_sh[LAST];

endmodule

// File: rtl/sgpio_rx_framer.sv
module sgpio_rx_framer
    import sgpio_rx_pkg::*;
#(
    parameter int STREAM_SLOTS = 8,
    parameter int MIN_LOW      = 5,
    parameter int SW           = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_ev,
    input  logic          frm_s,
    output fr_state_t     state,
    output logic          bit_we,
    output logic [SW-1:0] cur_slot,
    output fld_t          cur_fld,
    output logic          commit
);
    localparam int LW = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;

    fr_state_t     nxt;
    logic [LW-1:0] low_cnt;
    logic          last_bit;

    assign last_bit = (cur_slot == SW'(STREAM_SLOTS - 1)) && (cur_fld == FLD_FAIL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT: begin
                if (sample_ev && !frm_s && (low_cnt == LW'(MIN_LOW - 1)))
                    nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (sample_ev && frm_s) nxt = ST_FRAME;
            end
            ST_FRAME: begin
                if (sample_ev) begin
                    if (frm_s)         nxt = ST_HUNT;
                    else if (last_bit) nxt = ST_COMMIT;
                end
            end
            ST_COMMIT: nxt = ST_ARMED;
        endcase
    end

    // low-run counter and bit position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            cur_slot <= '0;
            cur_fld  <= FLD_ACT;
        end else begin
            if (state != ST_HUNT)
                low_cnt <= '0;
            else if (sample_ev)
                low_cnt <= frm_s ? '0 : low_cnt + LW'(1);

            if (bit_we) begin
                if (last_bit) begin
                    cur_slot <= '0;
                    cur_fld  <= FLD_ACT;
                end else begin
                    unique case (cur_fld)
                        FLD_ACT:  cur_fld <= FLD_LOC;
                        FLD_LOC:  cur_fld <= FLD_FAIL;
                        FLD_FAIL: begin
                            cur_fld  <= FLD_ACT;
                            cur_slot <= cur_slot + SW'(1);
                        end
                        default:  cur_fld <= FLD_ACT;
                    endcase
                end
            end else if (state != ST_FRAME) begin
                cur_slot <= '0;
                cur_fld  <= FLD_ACT;
            end
        end
    end

    // outputs
    always_comb begin
        bit_we = 1'b0;
        commit = 1'b0;
        unique case (state)
            ST_HUNT:   ;
            ST_ARMED:  bit_we = sample_ev && frm_s;
            ST_FRAME:  bit_we = sample_ev && !frm_s;
            ST_COMMIT: commit = 1'b1;
        endcase
    end

endmodule

// File: rtl/sgpio_rx_slot_regs.sv
module sgpio_rx_slot_regs
    import sgpio_rx_pkg::*;
#(
    parameter int NUM_SLOTS    = 8,
    parameter int STREAM_SLOTS = 8,
    parameter int SW           = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_we,
    input  logic [SW-1:0]        bit_slot,
    input  fld_t                 bit_fld,
    input  logic                 bit_val,
    input  logic                 commit,
    output logic [NUM_SLOTS-1:0] slot_act,
    output logic [NUM_SLOTS-1:0] slot_loc,
    output logic [NUM_SLOTS-1:0] slot_fail,
    output logic                 frame_stb
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (g < STREAM_SLOTS) begin : g_live
            logic sh_act, sh_loc, sh_fail;
            logic q_act, q_loc, q_fail;
            logic hit;

            assign hit = bit_we && (bit_slot == SW'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh_act  <= 1'b0;
                    sh_loc  <= 1'b0;
                    sh_fail <= 1'b0;
                    q_act   <= 1'b0;
                    q_loc   <= 1'b0;
                    q_fail  <= 1'b0;
                end else begin
                    if (hit && bit_fld == FLD_ACT)  sh_act  <= bit_val;
                    if (hit && bit_fld == FLD_LOC)  sh_loc  <= bit_val;
                    if (hit && bit_fld == FLD_FAIL) sh_fail <= bit_val;
                    if (commit) begin
                        q_act  <= sh_act;
                        q_loc  <= sh_loc;
                        q_fail <= sh_fail;
                    end
                end
            end

            assign slot_act[g]  = q_act;
            assign slot_loc[g]  = q_loc;
            assign slot_fail[g] = q_fail;
        end else begin : g_absent
            // R8: a slot the stream never carries reads zero
            assign slot_act[g]  = 1'b0;
            assign slot_loc[g]  = 1'b0;
            assign slot_fail[g] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_stb <= 1'b0;
        else        frame_stb <= commit;
    end

endmodule

// File: rtl/sgpio_rx_tx.sv
module sgpio_rx_tx
    import sgpio_rx_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SW        = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_ev,
    input  logic [SW-1:0]        tx_slot,
    input  fld_t                 tx_fld,
    input  logic [NUM_SLOTS-1:0] rsp_b0,
    input  logic [NUM_SLOTS-1:0] rsp_b1,
    input  logic [NUM_SLOTS-1:0] rsp_b2,
    output logic                 ser_dout
);
    logic pick;

    // R7: positions beyond the held slots return zero
    always_comb begin
        pick = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (int'(tx_slot) == i) begin
                unique case (tx_fld)
                    FLD_ACT:  pick = rsp_b0[i];
                    FLD_LOC:  pick = rsp_b1[i];
                    FLD_FAIL: pick = rsp_b2[i];
                    default:  pick = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ser_dout <= 1'b0;
        else if (launch_ev) ser_dout <= pick;
    end

endmodule

// File: rtl/sgpio_target_rx.sv
module sgpio_target_rx
    import sgpio_rx_pkg::*;
#(
    parameter int NUM_SLOTS    = 8,
    parameter int STREAM_SLOTS = 8,
    parameter int MIN_LOW      = 5,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_frm,
    input  logic                 ser_din,
    input  logic [NUM_SLOTS-1:0] rsp_b0,
    input  logic [NUM_SLOTS-1:0] rsp_b1,
    input  logic [NUM_SLOTS-1:0] rsp_b2,
    output logic                 ser_dout,
    output logic [NUM_SLOTS-1:0] slot_act,
    output logic [NUM_SLOTS-1:0] slot_loc,
    output logic [NUM_SLOTS-1:0] slot_fail,
    output logic                 frame_stb
);
    localparam int SW = $clog2(STREAM_SLOTS + 1);

    logic          sample_ev, launch_ev, frm_s, din_s;
    fr_state_t     fr_state;
    logic          bit_we, commit;
    logic [SW-1:0] cur_slot;
    fld_t          cur_fld;

    sgpio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_frm   (ser_frm),
        .ser_din   (ser_din),
        .sample_ev (sample_ev),
        .launch_ev (launch_ev),
        .frm_s     (frm_s),
        .din_s     (din_s)
    );

    sgpio_rx_framer #(
        .STREAM_SLOTS (STREAM_SLOTS),
        .MIN_LOW      (MIN_LOW),
        .SW           (SW)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_ev (sample_ev),
        .frm_s     (frm_s),
        .state     (fr_state),
        .bit_we    (bit_we),
        .cur_slot  (cur_slot),
        .cur_fld   (cur_fld),
        .commit    (commit)
    );

    sgpio_rx_slot_regs #(
        .NUM_SLOTS    (NUM_SLOTS),
        .STREAM_SLOTS (STREAM_SLOTS),
        .SW           (SW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_we    (bit_we),
        .bit_slot  (cur_slot),
        .bit_fld   (cur_fld),
        .bit_val   (din_s),
        .commit    (commit),
        .slot_act  (slot_act),
        .slot_loc  (slot_loc),
        .slot_fail (slot_fail),
        .frame_stb (frame_stb)
    );

    sgpio_rx_tx #(
        .NUM_SLOTS (NUM_SLOTS),
        .SW        (SW)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_ev (launch_ev),
        .tx_slot   (cur_slot),
        .tx_fld    (cur_fld),
        .rsp_b0    (rsp_b0),
        .rsp_b1    (rsp_b1),
        .rsp_b2    (rsp_b2),
        .ser_dout  (ser_dout)
    );

endmodule

// File: rtl/sgpio_target_rx_chk.sv
module sgpio_target_rx_chk
    import sgpio_rx_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input fr_state_t            fr_state,
    input logic                 sample_ev,
    input logic                 launch_ev,
    input logic                 frm_s,
    input logic                 ser_dout,
    input logic [NUM_SLOTS-1:0] slot_act,
    input logic [NUM_SLOTS-1:0] slot_loc,
    input logic [NUM_SLOTS-1:0] slot_fail,
    input logic                 frame_stb
);

    // R2
    frame_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_state == ST_FRAME && $past(fr_state) != ST_FRAME) |-> $past(fr_state) == ST_ARMED);

    // R4
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |-> ($stable(slot_act) && $stable(slot_loc) && $stable(slot_fail)));

    // R5
    abort_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_state == ST_FRAME && sample_ev && frm_s) |=> fr_state == ST_HUNT);

    // R6
    dout_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(launch_ev) |-> $stable(ser_dout));

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

    // R9
    stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> $past(fr_state) == ST_COMMIT);

endmodule

bind sgpio_target_rx sgpio_target_rx_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fr_state  (fr_state),
    .sample_ev (sample_ev),
    .launch_ev (launch_ev),
    .frm_s     (frm_s),
    .ser_dout  (ser_dout),
    .slot_act  (slot_act),
    .slot_loc  (slot_loc),
    .slot_fail (slot_fail),
    .frame_stb (frame_stb)
);

// File: tb/test_sgpio_target_rx.sv
`timescale 1ns/1ps
module test_sgpio_target_rx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic ser_clk = 1'b0, ser_frm = 1'b0, ser_din = 1'b0;
    logic [7:0] ra0 = 8'hA5, ra1 = 8'h3C, ra2 = 8'h96;
    logic [2:0] rb0 = 3'b101, rb1 = 3'b011, rb2 = 3'b110;

    logic       dout_a, stb_a, dout_b, stb_b;
    logic [7:0] act_a, loc_a, fail_a;
    logic [2:0] act_b, loc_b, fail_b;

    // A: 8 held slots, 6-slot stream (slots 6,7 absent)
    sgpio_target_rx #(.NUM_SLOTS(8), .STREAM_SLOTS(6)) i_sgpio_target_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_frm(ser_frm), .ser_din(ser_din),
        .rsp_b0(ra0), .rsp_b1(ra1), .rsp_b2(ra2), .ser_dout(dout_a),
        .slot_act(act_a), .slot_loc(loc_a), .slot_fail(fail_a), .frame_stb(stb_a));

    // B: 3 held slots, 4-slot stream (slot 3 ignored)
    sgpio_target_rx #(.NUM_SLOTS(3), .STREAM_SLOTS(4)) i_sgpio_target_rx_b (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_frm(ser_frm), .ser_din(ser_din),
        .rsp_b0(rb0), .rsp_b1(rb1), .rsp_b2(rb2), .ser_dout(dout_b),
        .slot_act(act_b), .slot_loc(loc_b), .slot_fail(fail_b), .frame_stb(stb_b));

    int n_tests = 0, n_fail = 0, n_stb_a = 0, n_stb_b = 0;
    bit done = 1'b0;
    logic [7:0] ea_act = '0, ea_loc = '0, ea_fail = '0;
    logic [2:0] eb_act = '0, eb_loc = '0, eb_fail = '0;

    always @(posedge clk) begin
        if (stb_a) n_stb_a++;
        if (stb_b) n_stb_b++;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        chk(req, "A act",  {24'b0, act_a},  {24'b0, ea_act});
        chk(req, "A loc",  {24'b0, loc_a},  {24'b0, ea_loc});
        chk(req, "A fail", {24'b0, fail_a}, {24'b0, ea_fail});
        chk(req, "B act",  {29'b0, act_b},  {29'b0, eb_act});
        chk(req, "B loc",  {29'b0, loc_b},  {29'b0, eb_loc});
        chk(req, "B fail", {29'b0, fail_b}, {29'b0, eb_fail});
    endtask

    function automatic logic exp_tx(input int p, input logic [7:0] b0, input logic [7:0] b1,
                                    input logic [7:0] b2, input int ns);
        int s = p / 3;
        if (s >= ns) return 1'b0;
        case (p % 3)
            0:       return b0[s];
            1:       return b1[s];
            default: return b2[s];
        endcase
    endfunction

    task automatic bit_cycle(input logic frm, input logic d, input int p, input bit ca, input bit cb);
        ser_clk = 1'b1; ser_frm = frm; ser_din = d;
        #45;
        if (ca) chk("R6", "dout A", {31'b0, dout_a}, {31'b0, exp_tx(p, ra0, ra1, ra2, 8)});
        if (cb) chk((p >= 9) ? "R7" : "R6", "dout B", {31'b0, dout_b},
                    {31'b0, exp_tx(p, {5'b0, rb0}, {5'b0, rb1}, {5'b0, rb2}, 3)});
        #5 ser_clk = 1'b0;
        #50;
    endtask

    task automatic send_lows(input int n);
        for (int i = 0; i < n; i++) bit_cycle(1'b0, 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic send_frame(input logic [17:0] bits, input int abort_at, input bit accept, input string req);
        int sa0 = n_stb_a;
        int sb0 = n_stb_b;
        bit a_done, b_done;
        for (int p = 0; p < 18; p++) begin
            if (p == abort_at) begin
                bit_cycle(1'b1, bits[p], p, 1'b0, 1'b0);
                break;
            end
            bit_cycle(p == 0, bits[p], p, accept, accept && p < 12);
            if (p == 10) chk_outputs("R4");
        end
        a_done = accept && abort_at < 0;
        b_done = accept && (abort_at < 0 || abort_at >= 12);
        if (a_done) begin
            for (int s = 0; s < 8; s++) begin
                ea_act[s]  = (s < 6) ? bits[3*s]   : 1'b0;
                ea_loc[s]  = (s < 6) ? bits[3*s+1] : 1'b0;
                ea_fail[s] = (s < 6) ? bits[3*s+2] : 1'b0;
            end
        end
        if (b_done) begin
            for (int s = 0; s < 3; s++) begin
                eb_act[s]  = bits[3*s];
                eb_loc[s]  = bits[3*s+1];
                eb_fail[s] = bits[3*s+2];
            end
        end
        #20;
        chk_outputs(req);
        chk("R9", "A strobes", n_stb_a - sa0, a_done ? 1 : 0);
        chk("R9", "B strobes", n_stb_b - sb0, b_done ? 1 : 0);
    endtask

    task automatic t_reset();
        chk_outputs("R1");
        chk("R1", "dout A", {31'b0, dout_a}, 0);
        chk("R1", "dout B", {31'b0, dout_b}, 0);
        chk("R1", "strobes", n_stb_a + n_stb_b, 0);
    endtask

    task automatic t_short_run();
        send_lows(4);
        send_frame(18'h3FFFF, -1, 1'b0, "R2");
    endtask

    task automatic t_order();
        send_frame(18'h2B5C9, -1, 1'b1, "R3");
        send_frame(18'h0C30F, -1, 1'b1, "R3");
    endtask

    task automatic t_absent_and_ignored();
        send_frame(18'h3FFFF, -1, 1'b1, "R7");
        chk("R8", "A slots 7:6", {26'b0, act_a[7:6], loc_a[7:6], fail_a[7:6]}, 0);
    endtask

    task automatic t_back_to_back();
        send_frame(18'h15555, -1, 1'b1, "R10");
        send_frame(18'h2AAAA, -1, 1'b1, "R10");
    endtask

    task automatic t_abort();
        send_frame(18'h0F0F3, 7, 1'b1, "R5");
        send_lows(5);
        send_frame(18'h33333, -1, 1'b1, "R2");
        send_frame(18'h1E1E1, 14, 1'b1, "R5");
        send_lows(2);
        send_frame(18'h3FFFF, -1, 1'b0, "R5");
        send_frame(18'h24924, -1, 1'b1, "R3");
    endtask

    initial begin
        repeat (10) @(posedge clk);
        #1.3;
        rst_n = 1'b1;
        #20;
        t_reset();
        t_short_run();
        t_order();
        t_absent_and_ignored();
        t_back_to_back();
        t_abort();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule